// File: doc/BRIEF.md
# Paired-Accumulator Word and Pointer Execution Unit

This unit carries out the word-wide and register-to-register operations of a small 8-bit controller core. It holds two byte accumulators, `acc_a` and `acc_b`, which read together as one 16-bit word with `acc_a` as the upper byte. It also holds a 16-bit index pointer, a 16-bit stack pointer and a six-bit condition register. The decoder upstream presents one operation code with a valid strobe, together with a 16-bit operand already fetched from memory. Every result and flag update is registered on the clock edge where the strobe is high.

The operations are:
- word add and word subtract with the operand;
- a one-bit left or right shift of the paired word;
- an unsigned byte multiply into the paired word;
- adding the low accumulator into the index pointer;
- swapping the paired word with the index pointer;
- moving a value between the two pointers with a one-step offset;
- stepping either pointer up or down by one.

The condition rules differ between operations. Some operations write flags, some leave them all alone, and the index steps touch only the zero flag.

The unit keeps no sequencing state. Every operation completes in one cycle. The next-state logic is a single case statement over the operation code, and one register process holds the architectural state.

Top module: `exu_core`

## Requirements
- R1: A synchronous reset clears both accumulators, both pointers and the condition register `ccr`. The bits of `ccr` are half-carry 5, interrupt mask 4, negative 3, zero 2, overflow 1 and carry 0.
- R2: Op code 1 (word add) writes D+operand into the paired word. It sets negative from result bit 15 and zero for a zero result. Overflow is set on signed overflow. Carry takes the carry out of bit 15.
- R3: Op code 2 (word subtract) writes D−operand into the paired word. Negative and zero follow the result. Overflow is set on signed overflow. Carry is set when the operand is larger than D as unsigned numbers.
- R4: Op code 3 (word left shift) shifts D left by one and feeds a zero into bit 0. Carry takes the old bit 15, negative and zero follow the result, and overflow becomes negative XOR carry.
- R5: Op code 4 (word right shift) shifts D right by one and feeds a zero into bit 15. Carry takes the old bit 0, negative becomes 0, zero follows the result, and overflow becomes negative XOR carry.
- R6: Op code 5 adds `acc_b`, zero-extended, to the index pointer. It leaves every `ccr` bit unchanged.
- R7: Op code 6 writes the unsigned product `acc_a`×`acc_b` into the paired word. Carry becomes bit 7 of the new `acc_b`, and no other flag changes.
- R8: Op code 7 swaps the paired word with the index pointer and leaves `ccr` unchanged.
- R9: Op code 8 loads the stack pointer with the index pointer minus 1. Op code 9 loads the index pointer with the stack pointer plus 1. Neither changes `ccr`.
- R10: Op codes 10 and 11 add 1 to and subtract 1 from the index pointer. They set the zero flag (`ccr` bit 2) when the result is zero and leave the other flags unchanged.
- R11: Op codes 12 and 13 add 1 to and subtract 1 from the stack pointer. They change no flag.
- R12: All registers keep their values while `op_valid` is low, whatever the op code. They also keep their values when op code 0, 14 or 15 is strobed.
- R13: The half-carry and interrupt-mask bits (`ccr` bits 5 and 4) stay 0 after reset under every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Strobe: execute `op_code` on this edge |
| op_code | input | 4 | Decoded operation code |
| operand | input | 16 | Memory operand for word add and subtract |
| acc_a | output | 8 | Upper accumulator (high byte of D) |
| acc_b | output | 8 | Lower accumulator (low byte of D) |
| idx_x | output | 16 | Index pointer |
| stk_p | output | 16 | Stack pointer |
| ccr | output | 6 | Condition flags {H,I,N,Z,V,C} |

## Verification
The bound checker checks on every cycle the operations whose effect follows from one earlier cycle of port values:
- the index add and the flags it leaves alone;
- the product and its carry rule;
- the swap;
- the offset transfers between the pointers;
- the pointer steps and the flags each one may touch;
- the hold when no strobe is given.

Only the bench shows the arithmetic flag values of the word add, the word subtract and the two shifts across a grid of operands. That grid includes the signed and unsigned wrap points. The bench also shows the zero-flag edges of the index steps and the wrap of the offset transfers at 0x0000 and 0xFFFF.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int OP_W = 4;
    localparam int CCR_W = 6;

    localparam int F_H = 5;
    localparam int F_I = 4;
    localparam int F_N = 3;
    localparam int F_Z = 2;
    localparam int F_V = 1;
    localparam int F_C = 0;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 4'd0,
        OP_WADD  = 4'd1,
        OP_WSUB  = 4'd2,
        OP_WSHL  = 4'd3,
        OP_WSHR  = 4'd4,
        OP_XADDB = 4'd5,
        OP_BMUL  = 4'd6,
        OP_SWAP  = 4'd7,
        OP_X2S   = 4'd8,
        OP_S2X   = 4'd9,
        OP_XINC  = 4'd10,
        OP_XDEC  = 4'd11,
        OP_SINC  = 4'd12,
        OP_SDEC  = 4'd13,
        OP_RSV0  = 4'd14,
        OP_RSV1  = 4'd15
    } exu_op_e;
endpackage

// File: rtl/exu_word_alu.sv
module exu_word_alu
    import exu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  exu_op_e             op,
    input  logic [WORD_W-1:0]   d_in,
    input  logic [WORD_W-1:0]   m_in,
    output logic [WORD_W-1:0]   res,
    output logic                f_n,
    output logic                f_z,
    output logic                f_v,
    output logic                f_c
);
    localparam int MSB = WORD_W - 1;

    logic [WORD_W:0] sum_w;
    logic [WORD_W:0] dif_w;

    assign sum_w = {1'b0, d_in} + {1'b0, m_in};
    assign dif_w = {1'b0, d_in} - {1'b0, m_in};

    always_comb begin
        res = d_in;
        f_v = 1'b0;
        f_c = 1'b0;
        unique case (op)
            OP_WADD: begin
                res = sum_w[MSB:0];
                f_c = sum_w[WORD_W];
                f_v = (d_in[MSB] == m_in[MSB]) && (sum_w[MSB] != d_in[MSB]);
            end
            OP_WSUB: begin
                res = dif_w[MSB:0];
                f_c = dif_w[WORD_W];
                f_v = (d_in[MSB] != m_in[MSB]) && (dif_w[MSB] != d_in[MSB]);
            end
            OP_WSHL: begin
                res = {d_in[MSB-1:0], 1'b0};
                f_c = d_in[MSB];
                f_v = d_in[MSB-1] ^ d_in[MSB];
            end
            OP_WSHR: begin
                res = {1'b0, d_in[MSB:1]};
                f_c = d_in[0];
                f_v = d_in[0];
            end
            default: ;
        endcase
    end

    assign f_n = res[MSB];
    assign f_z = (res == '0);
endmodule

// File: rtl/exu_byte_mul.sv
module exu_byte_mul #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0]   mc,
    input  logic [BYTE_W-1:0]   mp,
    output logic [2*BYTE_W-1:0] prod
);
    logic [2*BYTE_W-1:0] part [BYTE_W];

    for (genvar k = 0; k < BYTE_W; k++) begin : g_part
        assign part[k] = mp[k] ? ({{BYTE_W{1'b0}}, mc} << k) : '0;
    end

    always_comb begin
        prod = '0;
        for (int k = 0; k < BYTE_W; k++) begin
            prod = prod + part[k];
        end
    end
endmodule

// File: rtl/exu_ptr_unit.sv
module exu_ptr_unit
    import exu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  exu_op_e               op,
    input  logic [2*BYTE_W-1:0]   x_in,
    input  logic [2*BYTE_W-1:0]   s_in,
    input  logic [BYTE_W-1:0]     b_in,
    output logic [2*BYTE_W-1:0]   x_out,
    output logic [2*BYTE_W-1:0]   s_out
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    always_comb begin
        x_out = x_in;
        s_out = s_in;
        unique case (op)
            OP_XADDB: x_out = x_in + {{BYTE_W{1'b0}}, b_in};
            OP_S2X:   x_out = s_in + ONE;
            OP_XINC:  x_out = x_in + ONE;
            OP_XDEC:  x_out = x_in - ONE;
            OP_X2S:   s_out = x_in - ONE;
            OP_SINC:  s_out = s_in + ONE;
            OP_SDEC:  s_out = s_in - ONE;
            default: ;
        endcase
    end
endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  op_valid,
    input  logic [3:0]            op_code,
    input  logic [2*BYTE_W-1:0]   operand,
    output logic [BYTE_W-1:0]     acc_a,
    output logic [BYTE_W-1:0]     acc_b,
    output logic [2*BYTE_W-1:0]   idx_x,
    output logic [2*BYTE_W-1:0]   stk_p,
    output logic [5:0]            ccr
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] d_q, d_n;
    logic [WORD_W-1:0] x_q, x_n;
    logic [WORD_W-1:0] s_q, s_n;
    logic [CCR_W-1:0]  f_q, f_n;

    exu_op_e op;
    assign op = exu_op_e'(op_code);

    logic [WORD_W-1:0] alu_res;
    logic              alu_n, alu_z, alu_v, alu_c;
    logic [WORD_W-1:0] mul_res;
    logic [WORD_W-1:0] px_res, ps_res;

    exu_word_alu #(.WORD_W(WORD_W)) u_alu (
        .op   (op),
        .d_in (d_q),
        .m_in (operand),
        .res  (alu_res),
        .f_n  (alu_n),
        .f_z  (alu_z),
        .f_v  (alu_v),
        .f_c  (alu_c)
    );

    exu_byte_mul #(.BYTE_W(BYTE_W)) u_mul (
        .mc   (d_q[WORD_W-1:BYTE_W]),
        .mp   (d_q[BYTE_W-1:0]),
        .prod (mul_res)
    );

    exu_ptr_unit #(.BYTE_W(BYTE_W)) u_ptr (
        .op    (op),
        .x_in  (x_q),
        .s_in  (s_q),
        .b_in  (d_q[BYTE_W-1:0]),
        .x_out (px_res),
        .s_out (ps_res)
    );

    // next-state selection
    always_comb begin
        d_n = d_q;
        x_n = x_q;
        s_n = s_q;
        f_n = f_q;
        if (op_valid) begin
            unique case (op)
                OP_WADD, OP_WSUB, OP_WSHL, OP_WSHR: begin
                    d_n      = alu_res;
                    f_n[F_N] = alu_n;
                    f_n[F_Z] = alu_z;
                    f_n[F_V] = alu_v;
                    f_n[F_C] = alu_c;
                end
                OP_BMUL: begin
                    d_n      = mul_res;
                    f_n[F_C] = mul_res[BYTE_W-1];
                end
                OP_SWAP: begin
                    d_n = x_q;
                    x_n = d_q;
                end
                OP_XADDB, OP_S2X: x_n = px_res;
                OP_XINC, OP_XDEC: begin
                    x_n      = px_res;
                    f_n[F_Z] = (px_res == '0);
                end
                OP_X2S, OP_SINC, OP_SDEC: s_n = ps_res;
                default: ;
            endcase
        end
    end

    // architectural state register
    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= '0;
            x_q <= '0;
            s_q <= '0;
            f_q <= '0;
        end else begin
            d_q <= d_n;
            x_q <= x_n;
            s_q <= s_n;
            f_q <= f_n;
        end
    end

    assign acc_a = d_q[WORD_W-1:BYTE_W];
    assign acc_b = d_q[BYTE_W-1:0];
    assign idx_x = x_q;
    assign stk_p = s_q;
    assign ccr   = f_q;
endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk
    import exu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  op_valid,
    input logic [3:0]            op_code,
    input logic [2*BYTE_W-1:0]   operand,
    input logic [BYTE_W-1:0]     acc_a,
    input logic [BYTE_W-1:0]     acc_b,
    input logic [2*BYTE_W-1:0]   idx_x,
    input logic [2*BYTE_W-1:0]   stk_p,
    input logic [5:0]            ccr
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    logic [WORD_W-1:0] dw;
    assign dw = {acc_a, acc_b};

    logic unused_ok;
    assign unused_ok = ^operand;

    a_r6_index_add: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_XADDB) |=>
            (idx_x == $past(idx_x + {{BYTE_W{1'b0}}, acc_b})) && (ccr == $past(ccr)));

    a_r7_product: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_BMUL) |=>
            (dw == $past(WORD_W'(acc_a) * WORD_W'(acc_b))) && (ccr[F_C] == acc_b[BYTE_W-1])
            && (ccr[5:1] == $past(ccr[5:1])));

    a_r8_swap: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_SWAP) |=>
            (idx_x == $past(dw)) && (dw == $past(idx_x)) && (ccr == $past(ccr)));

    a_r9_x_to_s: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_X2S) |=> (stk_p == $past(idx_x) - ONE) && $stable(idx_x));

    a_r9_s_to_x: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_S2X) |=> (idx_x == $past(stk_p) + ONE) && $stable(stk_p));

    a_r10_x_step: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_XINC || op_code == OP_XDEC)) |=>
            ({ccr[5:3], ccr[1:0]} == $past({ccr[5:3], ccr[1:0]}))
            && (ccr[F_Z] == (idx_x == '0)));

    a_r11_s_step: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_SINC || op_code == OP_SDEC)) |=>
            $stable(ccr) && $stable(idx_x) && $stable(dw));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(dw) && $stable(idx_x) && $stable(stk_p) && $stable(ccr));

    a_r13_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (ccr[F_H] == 1'b0) && (ccr[F_I] == 1'b0));
endmodule

bind exu_core exu_core_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .operand  (operand),
    .acc_a    (acc_a),
    .acc_b    (acc_b),
    .idx_x    (idx_x),
    .stk_p    (stk_p),
    .ccr      (ccr)
);

// File: tb/exu_core_tb_top.sv
`timescale 1ns/1ps
module exu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [15:0] operand = 16'd0;
    logic [7:0]  acc_a, acc_b;
    logic [15:0] idx_x, stk_p;
    logic [5:0]  ccr;

    always #4 clk = ~clk;

    exu_core #(.BYTE_W(8)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .acc_a(acc_a), .acc_b(acc_b), .idx_x(idx_x),
        .stk_p(stk_p), .ccr(ccr)
    );

    int tests = 0;
    int fails = 0;

    logic [15:0] m_d, m_x, m_s;
    logic [5:0]  m_f;

    function automatic logic [15:0] pick(int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'hFFFE;
            6: return 16'h0080;
            7: return 16'h00FF;
            default: return 16'(k * 1021) ^ 16'(k << 10);
        endcase
    endfunction

    task automatic check(string req);
        tests++;
        if ({acc_a, acc_b} !== m_d || idx_x !== m_x || stk_p !== m_s || ccr !== m_f) begin
            fails++;
            $display("FAIL %s: got D=%h X=%h S=%h F=%b, expected D=%h X=%h S=%h F=%b",
                     req, {acc_a, acc_b}, idx_x, stk_p, ccr, m_d, m_x, m_s, m_f);
        end
    endtask

    // expected-state update from the requirement text
    task automatic model(input logic [3:0] op, input logic [15:0] m);
        logic [16:0] w;
        logic [15:0] r;
        case (op)
            4'd1: begin
                w = 17'(m_d) + 17'(m);
                r = w[15:0];
                m_f[0] = w[16];
                m_f[1] = (m_d[15] == m[15]) && (r[15] != m_d[15]);
                m_f[3] = r[15]; m_f[2] = (r == 0); m_d = r;
            end
            4'd2: begin
                r = m_d - m;
                m_f[0] = (m > m_d);
                m_f[1] = (m_d[15] != m[15]) && (r[15] != m_d[15]);
                m_f[3] = r[15]; m_f[2] = (r == 0); m_d = r;
            end
            4'd3: begin
                r = m_d * 2;
                m_f[0] = m_d[15]; m_f[3] = r[15]; m_f[2] = (r == 0);
                m_f[1] = m_f[3] ^ m_f[0]; m_d = r;
            end
            4'd4: begin
                r = m_d / 2;
                m_f[0] = m_d[0]; m_f[3] = 1'b0; m_f[2] = (r == 0);
                m_f[1] = m_f[3] ^ m_f[0]; m_d = r;
            end
            4'd5: m_x = m_x + 16'(m_d[7:0]);
            4'd6: begin
                m_d = 16'(m_d[15:8]) * 16'(m_d[7:0]);
                m_f[0] = m_d[7];
            end
            4'd7: begin r = m_d; m_d = m_x; m_x = r; end
            4'd8: m_s = m_x - 16'd1;
            4'd9: m_x = m_s + 16'd1;
            4'd10: begin m_x = m_x + 16'd1; m_f[2] = (m_x == 0); end
            4'd11: begin m_x = m_x - 16'd1; m_f[2] = (m_x == 0); end
            4'd12: m_s = m_s + 16'd1;
            4'd13: m_s = m_s - 16'd1;
            default: ;
        endcase
    endtask

    task automatic do_op(input logic [3:0] op, input logic [15:0] m, input string req);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; operand = m;
        model(op, m);
        @(negedge clk);
        op_valid = 1'b0;
        check(req);
    endtask

    task automatic set_d(input logic [15:0] v);
        do_op(4'd1, v - m_d, "R2");
    endtask

    task automatic set_x(input logic [15:0] v);
        set_d(v);
        do_op(4'd7, 16'h0, "R8");
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_d = 0; m_x = 0; m_s = 0; m_f = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1");

        // word add and subtract over an operand grid
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                set_d(pick(i));
                do_op(4'd1, pick(j), "R2");
                set_d(pick(i));
                do_op(4'd2, pick(j), "R3");
            end
        end

        // shifts
        for (int i = 0; i < 64; i++) begin
            set_d(pick(i));
            do_op(4'd3, 16'h0, "R4");
            set_d(pick(i));
            do_op(4'd4, 16'h0, "R5");
        end

        // multiply
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                set_d({8'(i * 17), 8'(j * 17)});
                do_op(4'd6, 16'h0, "R7");
            end
        end

        // index add, swap, transfers and steps
        for (int i = 0; i < 64; i++) begin
            set_x(pick(i));
            set_d(pick(63 - i));
            do_op(4'd5, 16'h0, "R6");
            do_op(4'd7, 16'h0, "R8");
            do_op(4'd8, 16'h0, "R9");
            do_op(4'd9, 16'h0, "R9");
            do_op(4'd10, 16'h0, "R10");
            do_op(4'd11, 16'h0, "R10");
            do_op(4'd11, 16'h0, "R10");
            do_op(4'd12, 16'h0, "R11");
            do_op(4'd13, 16'h0, "R11");
            do_op(4'd13, 16'h0, "R11");
        end

        // zero-flag edges of index steps and pointer wrap
        set_x(16'hFFFF);
        do_op(4'd10, 16'h0, "R10");
        do_op(4'd10, 16'h0, "R10");
        do_op(4'd11, 16'h0, "R10");
        set_x(16'h0000);
        do_op(4'd8, 16'h0, "R9");
        do_op(4'd9, 16'h0, "R9");

        // strobe low and reserved codes
        set_d(16'h1234);
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            op_valid = 1'b0; op_code = 4'(c); operand = 16'hA5A5;
            @(negedge clk);
            check("R12");
        end
        do_op(4'd0, 16'h5555, "R12");
        do_op(4'd14, 16'h5555, "R12");
        do_op(4'd15, 16'hFFFF, "R12");

        // fixed flag bits after a mix of operations
        do_op(4'd2, 16'h1235, "R13");
        tests++;
        if (ccr[5:4] !== 2'b00) begin
            fails++;
            $display("FAIL R13: got H,I=%b, expected 00", ccr[5:4]);
        end

        // reset again from non-zero state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_d = 0; m_x = 0; m_s = 0; m_f = 0;
        @(negedge clk);
        check("R1");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule